// File: doc/BRIEF.md
# Standby and Oscillation Wait Controller

This block holds an 8-bit control register. Software writes it to put the chip into one of two low-power modes, or to ask for a software reset. Sleep mode gates only the CPU clock. Stop mode gates the CPU clock and the peripheral clock and turns the oscillator off. An external wake-up input ends sleep at once. When wake-up ends stop mode, the oscillator enable rises first. A stabilization counter then runs for a power-of-two interval, chosen by a two-bit field, and only after that are both clocks released.

The counting clock can be the input clock or twice its rate, chosen by a gear input. At double rate the interval, measured in input-clock cycles, is halved. The interval field keeps its value through the ordinary reset and returns to its longest setting only on power-on reset. The parameter `WAIT_EXP0` sets the exponent of the shortest interval. The default is 15, and the four field values select 2^WAIT_EXP0, 2^(WAIT_EXP0+2), 2^(WAIT_EXP0+4) and 2^(WAIT_EXP0+6) counting-clock cycles.

Top module: `stby_ctrl`

## Requirements
- R1: After power-on reset, `rd_data` reads 8'b0001_1100. `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `busy` and `srst_req` are 0.
- R2: A write with bit 7 = 1 and bit 6 = 0, made while running, enters stop mode from the next cycle. In stop mode `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0, and `rd_data[7]` reads 1.
- R3: A write with bit 6 = 1 and bit 7 = 0, made while running, enters sleep mode. In sleep mode `cpu_clk_en` is 0, `per_clk_en` and `osc_en` stay 1, and `rd_data[6]` reads 1.
- R4: A write with both bit 7 and bit 6 set enters stop mode, not sleep mode.
- R5: An accepted write with bit 4 = 0 makes `srst_req` high for exactly the one cycle after the write. `rd_data[4]` always reads 1.
- R6: `wake` in sleep mode returns to run mode on the next cycle. `cpu_clk_en` rises and `rd_data[6]` clears.
- R7: `wake` in stop mode raises `osc_en` and `busy` on the next cycle while both clocks stay gated. `busy` stays high for exactly 2^(WAIT_EXP0+2*OSC) cycles, where OSC = `rd_data[3:2]`, or half that count when `gear` = 1. In the cycle `busy` falls, both clocks are enabled and `rd_data[7]` reads 0.
- R8: Every accepted write loads bits 3:2 into the interval field. `rst` returns the block to run mode with all clocks enabled and leaves the field unchanged. Only `por` sets the field back to 11.
- R9: Writes are accepted only in run mode. A write in sleep mode, in stop mode or during the wait changes neither the mode, nor the field, nor the wait length, and produces no `srst_req`.
- R10: `rd_data` bits 5, 1 and 0 always read 0.
- R11: `wake` in run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset; keeps the interval field |
| por | input | 1 | Synchronous active-high power-on reset; resets everything |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| wake | input | 1 | External wake-up event |
| gear | input | 1 | 1: counting clock is twice the input clock |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| busy | output | 1 | Stabilization wait in progress |
| srst_req | output | 1 | One-cycle software reset request |

## Verification
The bench measures the exact length of `busy` for every interval setting and both gear values. A counter compare that is off by one, or a gear step that is wrong, would make the wait one cycle too long or twice as long. It writes both mode bits at once, to catch a design where sleep wins over stop. It also writes during sleep, stop and the wait, and then reads back the field and the mode. A design that accepted those writes would show a changed field, would fall back into a low-power mode, or would pulse `srst_req`. It pulses `rst` and `por` after a field change, which exposes a field tied to the wrong reset.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_STOP  = 2'd2,
        ST_WAIT  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_SLEEP = 2'd1,
        REQ_STOP  = 2'd2
    } req_e;

    localparam int BIT_STOP   = 7;
    localparam int BIT_SLEEP  = 6;
    localparam int BIT_SRST   = 4;
    localparam int BIT_OSC_HI = 3;
    localparam int BIT_OSC_LO = 2;

    localparam logic [1:0] OSC_POR = 2'b11;

    typedef struct packed {
        logic       stop;
        logic       sleep;
        logic       srst_n;
        logic [1:0] osc;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] d);
        cmd_t c;
        c.stop   = d[BIT_STOP];
        c.sleep  = d[BIT_SLEEP];
        c.srst_n = d[BIT_SRST];
        c.osc    = d[BIT_OSC_HI:BIT_OSC_LO];
        return c;
    endfunction

    // stop outranks sleep
    function automatic req_e pick_req(input cmd_t c);
        if (c.stop)
            return REQ_STOP;
        else if (c.sleep)
            return REQ_SLEEP;
        return REQ_NONE;
    endfunction

    function automatic logic [7:0] pack_status(input mode_e m, input logic [1:0] osc);
        logic [7:0] r;
        r = 8'h00;
        r[BIT_STOP]  = (m == ST_STOP) || (m == ST_WAIT);
        r[BIT_SLEEP] = (m == ST_SLEEP);
        r[BIT_SRST]  = 1'b1;
        r[BIT_OSC_HI:BIT_OSC_LO] = osc;
        return r;
    endfunction

endpackage

// File: rtl/stby_regs.sv
module stby_regs
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       wr_ok,
    input  cmd_t       cmd,
    output logic [1:0] osc,
    output req_e       req,
    output logic       srst_req
);

    // interval field: power-on reset only
    always_ff @(posedge clk) begin
        if (por)
            osc <= OSC_POR;
        else if (wr_ok)
            osc <= cmd.osc;
    end

    always_ff @(posedge clk) begin
        if (por || rst)
            srst_req <= 1'b0;
        else
            srst_req <= wr_ok && !cmd.srst_n;
    end

    always_comb begin
        req = REQ_NONE;
        if (wr_ok)
            req = pick_req(cmd);
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic  clk,
    input  logic  rst_any,
    input  req_e  req,
    input  logic  wake,
    input  logic  wait_done,
    output mode_e mode,
    output logic  wait_clr,
    output logic  wait_run
);

    mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            ST_RUN: begin
                if (req == REQ_STOP)
                    mode_nx = ST_STOP;
                else if (req == REQ_SLEEP)
                    mode_nx = ST_SLEEP;
            end
            ST_SLEEP: if (wake)      mode_nx = ST_RUN;
            ST_STOP:  if (wake)      mode_nx = ST_WAIT;
            ST_WAIT:  if (wait_done) mode_nx = ST_RUN;
            default:                 mode_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_any)
            mode <= ST_RUN;
        else
            mode <= mode_nx;
    end

    assign wait_clr = (mode == ST_STOP) && wake;
    assign wait_run = (mode == ST_WAIT);

endmodule

// File: rtl/stby_wait_cnt.sv
module stby_wait_cnt #(
    parameter int WAIT_EXP0 = 15
) (
    input  logic       clk,
    input  logic       rst_any,
    input  logic       clr,
    input  logic       run,
    input  logic       fast,
    input  logic [1:0] osc,
    output logic       done
);

    localparam int NSEL = 4;
    localparam int CW   = WAIT_EXP0 + 2 * (NSEL - 1) + 1;

    logic [CW-1:0] tgt [NSEL];
    logic [CW-1:0] cnt;
    logic [CW:0]   sum;
    logic [CW:0]   step;

    for (genvar i = 0; i < NSEL; i++) begin : g_tgt
        assign tgt[i] = CW'(1) << (WAIT_EXP0 + 2 * i);
    end

    assign step = {{(CW - 1){1'b0}}, fast, !fast};
    assign sum  = {1'b0, cnt} + step;
    assign done = run && (sum >= {1'b0, tgt[osc]});

    always_ff @(posedge clk) begin
        if (rst_any || clr)
            cnt <= '0;
        else if (run && !done)
            cnt <= sum[CW-1:0];
    end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int WAIT_EXP0 = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       wake,
    input  logic       gear,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       busy,
    output logic       srst_req
);

    mode_e      mode;
    req_e       req;
    cmd_t       cmd;
    logic [1:0] osc;
    logic       wr_ok;
    logic       rst_any;
    logic       wait_clr;
    logic       wait_run;
    logic       wait_done;
    logic       unused_wr_bits;

    assign rst_any        = rst || por;
    assign cmd            = decode_cmd(wr_data);
    assign wr_ok          = wr_en && (mode == ST_RUN);
    assign unused_wr_bits = ^{wr_data[5], wr_data[1:0]};

    stby_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .por      (por),
        .wr_ok    (wr_ok),
        .cmd      (cmd),
        .osc      (osc),
        .req      (req),
        .srst_req (srst_req)
    );

    stby_fsm i_fsm (
        .clk       (clk),
        .rst_any   (rst_any),
        .req       (req),
        .wake      (wake),
        .wait_done (wait_done),
        .mode      (mode),
        .wait_clr  (wait_clr),
        .wait_run  (wait_run)
    );

    stby_wait_cnt #(.WAIT_EXP0(WAIT_EXP0)) i_cnt (
        .clk     (clk),
        .rst_any (rst_any),
        .clr     (wait_clr),
        .run     (wait_run),
        .fast    (gear),
        .osc     (osc),
        .done    (wait_done)
    );

    assign cpu_clk_en = (mode == ST_RUN);
    assign per_clk_en = (mode == ST_RUN) || (mode == ST_SLEEP);
    assign osc_en     = (mode != ST_STOP);
    assign busy       = (mode == ST_WAIT);
    assign rd_data    = pack_status(mode, osc);

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       por,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       busy,
    input logic       srst_req
);

    p_osc_off_gates_r2: assert property (@(posedge clk) disable iff (rst || por)
        !osc_en |-> (!cpu_clk_en && !per_clk_en && rd_data[7]));

    p_sleep_keeps_per_r3: assert property (@(posedge clk) disable iff (rst || por)
        (!cpu_clk_en && per_clk_en) |-> (osc_en && !busy && rd_data[6] && !rd_data[7]));

    p_srst_one_cycle_r5: assert property (@(posedge clk) disable iff (rst || por)
        srst_req |=> !srst_req);

    p_wait_gated_r7: assert property (@(posedge clk) disable iff (rst || por)
        busy |-> (osc_en && !cpu_clk_en && !per_clk_en));

    p_wait_release_r7: assert property (@(posedge clk) disable iff (rst || por)
        $fell(busy) |-> (cpu_clk_en && per_clk_en && !rd_data[7]));

    p_ignore_in_wait_r9: assert property (@(posedge clk) disable iff (rst || por)
        (busy && wr_en) |=> ($stable(rd_data[3:2]) && !srst_req));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst || por)
        (rd_data[5] == 1'b0) && (rd_data[1:0] == 2'b00));

endmodule

bind stby_ctrl stby_ctrl_chk i_chk (.*);

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int EXP0       = 4;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wake = 1'b0;
    logic       gear = 1'b0;
    logic [7:0] rd_data;
    logic       cpu_clk_en, per_clk_en, osc_en, busy, srst_req;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stby_ctrl #(.WAIT_EXP0(EXP0)) i_stby_ctrl (
        .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wake(wake), .gear(gear), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .busy(busy), .srst_req(srst_req)
    );

    int checks = 0;
    int errors = 0;
    int m_mode = 0;          // 0 run, 1 sleep, 2 stop
    logic [1:0] m_osc = 2'b11;
    bit finished = 0;

    function automatic logic [7:0] exp_rd(int md, logic [1:0] o);
        return {md == 2, md == 1, 1'b0, 1'b1, o, 2'b00};
    endfunction

    function automatic int wait_len(logic [1:0] o, logic g);
        return (1 << (EXP0 + 2 * o)) >> g;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        chk({tag, " cpu_clk_en"}, int'(cpu_clk_en), int'(m_mode == 0));
        chk({tag, " per_clk_en"}, int'(per_clk_en), int'(m_mode != 2));
        chk({tag, " osc_en"},     int'(osc_en),     int'(m_mode != 2));
        chk({tag, " busy"},       int'(busy),       0);
        chk({tag, " rd_data"},    int'(rd_data),    int'(exp_rd(m_mode, m_osc)));
    endtask

    task automatic write_reg(string tag, logic [7:0] d);
        bit exp_srst;
        exp_srst = 0;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (m_mode == 0) begin
            m_osc = d[3:2];
            exp_srst = !d[4];
            if (d[7]) m_mode = 2;
            else if (d[6]) m_mode = 1;
        end
        chk({tag, " srst_req"}, int'(srst_req), int'(exp_srst));
        check_state(tag);
        if (exp_srst) begin
            @(negedge clk);
            chk({tag, " srst_req drop"}, int'(srst_req), 0);
        end
    endtask

    task automatic do_wake(string tag, logic g);
        int n;
        @(negedge clk);
        gear = g;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        if (m_mode == 1) begin
            m_mode = 0;
        end else if (m_mode == 2) begin
            chk({tag, " busy rise"},  int'(busy),       1);
            chk({tag, " osc_en rise"}, int'(osc_en),    1);
            chk({tag, " cpu gated"},  int'(cpu_clk_en), 0);
            n = 0;
            while (busy === 1'b1 && n < 20000) begin
                n++;
                @(negedge clk);
            end
            chk({tag, " wait length"}, n, wait_len(m_osc, g));
            m_mode = 0;
        end
        check_state(tag);
    endtask

    task automatic pulse_rst(string tag);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_mode = 0;
        check_state(tag);
    endtask

    task automatic pulse_por(string tag);
        @(negedge clk);
        por = 1'b1;
        @(negedge clk);
        por = 1'b0;
        m_mode = 0;
        m_osc = 2'b11;
        check_state(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int op;
        int seed;
        seed = $urandom(20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        por = 1'b0;
        @(negedge clk);
        // R1 and R10 reset state
        check_state("R1");
        chk("R1 rd_data value", int'(rd_data), 8'h1C);
        chk("R1 srst_req", int'(srst_req), 0);
        chk("R10 reserved", int'(rd_data & 8'h23), 0);

        write_reg("R3", 8'h50);
        write_reg("R9 write in sleep", 8'h8C);
        do_wake("R6", 1'b0);

        write_reg("R4", 8'hC4);
        write_reg("R9 write in stop", 8'h40);
        do_wake("R7 gear1", 1'b1);

        write_reg("R2", 8'h9C);
        do_wake("R7 osc11", 1'b0);

        write_reg("R5", 8'h0C);
        write_reg("R5 with stop", 8'hEC);
        chk("R10 reserved after write", int'(rd_data & 8'h23), 0);
        do_wake("R7 after R5", 1'b1);

        do_wake("R11", 1'b0);

        write_reg("R8", 8'h14);
        pulse_rst("R8 rst keeps osc");
        write_reg("R8 stop then rst", 8'h98);
        pulse_rst("R8 rst exits stop");
        pulse_por("R8 por");

        // R9: write issued in the middle of the wait
        write_reg("R9 setup", 8'h98);
        @(negedge clk);
        gear = 1'b0;
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        n = 0;
        while (busy === 1'b1 && n < 20000) begin
            if (n == 3) begin
                wr_en = 1'b1;
                wr_data = 8'h40;
            end
            if (n == 4) begin
                wr_en = 1'b0;
                chk("R9 no srst in wait", int'(srst_req), 0);
            end
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R9 wait length", n, wait_len(2'b10, 1'b0));
        m_mode = 0;
        check_state("R9 after wait");

        for (int i = 0; i < 60; i++) begin
            op = $urandom % 8;
            if (op < 4)
                write_reg("R8 random write", 8'($urandom));
            else if (op < 7)
                do_wake("R7 random wake", 1'($urandom));
            else
                pulse_rst("R8 random rst");
        end

        finish_run();
    end

endmodule